// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters. The table is addressed by the XOR of instruction-address bits with a register that records the outcomes of recent branches. Because the same branch address lands in different counters depending on the path that led to it, the block can learn branches whose outcome follows from earlier branches.

The fetch side presents a PC and gets a taken/not-taken guess in the same cycle. It also gets the current history value, which the pipeline carries along with the branch. When the branch resolves, the pipeline returns the branch PC, the real outcome and that carried history value. The block then trains the counter that the original guess read, and shifts the outcome into the history register.

By default the table has 2048 counters. Eleven word-address bits are combined with eight history bits. The table depth, the history length, the PC width and the byte-offset width are all parameters.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken), so every lookup predicts not taken, and the history register reads 0.
- R2: `fc_taken` equals bit 1 (the most significant bit) of the counter selected by `fc_pc` and the current history, in the same cycle and with no clock edge in between.
- R3: The table index is `pc[12:2]` XOR the history zero-extended on the left, so the history reaches only index bits [7:0]. PC bits [1:0] and all PC bits above bit 12 have no effect on the index.
- R4: A valid resolve with outcome taken adds 1 to the selected counter, and the counter stops at 3.
- R5: A valid resolve with outcome not taken subtracts 1 from the selected counter, and the counter stops at 0.
- R6: A resolve selects its counter from `rs_pc` and the returned snapshot `rs_hist`, never from the current history.
- R7: On each valid resolve the history shifts left by one and takes the outcome into bit 0 (1 = taken); the oldest bit is dropped. Without a valid resolve the history holds. `fc_hist` always shows the current history.
- R8: When a lookup and a resolve address the same counter in one cycle, the lookup returns the value held before that resolve.
- R9: While `rs_valid` is low, no counter changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_pc | input | 32 | Address of the branch being fetched |
| fc_taken | output | 1 | Guess for `fc_pc`: 1 = taken |
| fc_hist | output | 8 | Current history, carried with the branch as its snapshot |
| rs_valid | input | 1 | A branch has resolved this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch: 1 = taken |
| rs_hist | input | 8 | History snapshot taken when the branch was predicted |

## Verification
A lookup and a training update can hit the same counter in one cycle. The bench provokes this by first raising one counter to 2. In the next cycle it drives a not-taken resolve and a lookup that both select that counter. It then samples `fc_taken` before the clock edge and expects the old taken guess. After the edge it expects the lowered not-taken guess on the same counter, looked up with the new history. The bench keeps its own model of the history register and computes each lookup PC from it, so the expected index of every check is derived from the requirements alone.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN     = 2'd0;
    localparam ctr_t CTR_MAX     = 2'd3;
    localparam ctr_t CTR_RST_VAL = 2'd1;

    // saturating step of one counter
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t res;
        if (up) begin
            res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        end else begin
            res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        end
        return res;
    endfunction

endpackage

// File: rtl/gs_index.sv
module gs_index #(
    parameter int PC_W   = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 11,
    parameter int HIST_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] pc_bits;
    logic [IDX_W-1:0] hist_ext;

    assign pc_bits = pc[OFS_W +: IDX_W];

    generate
        if (HIST_W == IDX_W) begin : g_full
            assign hist_ext = hist;
        end else begin : g_low
            assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
        end
    endgenerate

    assign idx = pc_bits ^ hist_ext;

endmodule

// File: rtl/gs_ghr.sv
module gs_ghr #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } ghr_state_t;

    ghr_state_t st_d, st_q;
    logic [HIST_W-1:0] shifted;

    generate
        if (HIST_W == 1) begin : g_one
            assign shifted = bit_in;
        end else begin : g_many
            assign shifted = {st_q.bits[HIST_W-2:0], bit_in};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.bits;

    AST_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(bit_in)); // R7
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist)); // R7

endmodule

// File: rtl/gs_pht.sv
module gs_pht
    import gshare_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        ctr_t [ENTRIES-1:0] tbl;
    } pht_state_t;

    pht_state_t st_d, st_q;
    ctr_t       wr_old;

    assign wr_old = st_q.tbl[wr_idx];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tbl[wr_idx] = ctr_step(wr_old, wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= {ENTRIES{CTR_RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    // read sees registered state only: pre-update value on collision
    assign rd_ctr = st_q.tbl[rd_idx];

    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && wr_old != CTR_MAX)
        |=> st_q.tbl[$past(wr_idx)] == $past(wr_old) + 2'd1); // R4
    AST_CTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && wr_old == CTR_MAX)
        |=> st_q.tbl[$past(wr_idx)] == CTR_MAX); // R4
    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && wr_old != CTR_MIN)
        |=> st_q.tbl[$past(wr_idx)] == $past(wr_old) - 2'd1); // R5
    AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && wr_old == CTR_MIN)
        |=> st_q.tbl[$past(wr_idx)] == CTR_MIN); // R5
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> st_q.tbl[$past(rd_idx)] == $past(rd_ctr)); // R9

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int OFS_W   = 2,
    parameter int ENTRIES = 2048,
    parameter int HIST_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fc_pc,
    output logic              fc_taken,
    output logic [HIST_W-1:0] fc_hist,
    input  logic              rs_valid,
    input  logic [PC_W-1:0]   rs_pc,
    input  logic              rs_taken,
    input  logic [HIST_W-1:0] rs_hist
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [HIST_W-1:0] ghr;
    logic [IDX_W-1:0]  fc_idx;
    logic [IDX_W-1:0]  rs_idx;
    ctr_t              fc_ctr;

    gs_index #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_fc_index (
        .pc   (fc_pc),
        .hist (ghr),
        .idx  (fc_idx)
    );

    // training re-derives the index from the returned snapshot
    gs_index #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_rs_index (
        .pc   (rs_pc),
        .hist (rs_hist),
        .idx  (rs_idx)
    );

    gs_pht #(.IDX_W(IDX_W)) u_pht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (fc_idx),
        .rd_ctr (fc_ctr),
        .wr_en  (rs_valid),
        .wr_idx (rs_idx),
        .wr_up  (rs_taken)
    );

    gs_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rs_valid),
        .bit_in   (rs_taken),
        .hist     (ghr)
    );

    assign fc_taken = fc_ctr[1];
    assign fc_hist  = ghr;

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> fc_hist == $past(fc_hist)); // R7

endmodule

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fc_pc = '0;
    logic        fc_taken;
    logic [7:0]  fc_hist;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [7:0]  rs_hist = '0;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] exp_ghr = '0;

    always #5 clk = ~clk;

    gshare_predictor u_dut (
        .clk(clk), .rst_n(rst_n),
        .fc_pc(fc_pc), .fc_taken(fc_taken), .fc_hist(fc_hist),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_hist(rs_hist)
    );

    // PC whose word bits [12:2] XOR history give the wanted index
    function automatic logic [31:0] pc_for(input logic [10:0] idx, input logic [7:0] h);
        return {19'd0, idx ^ {3'd0, h}, 2'b00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic resolve(input logic [31:0] pc, input logic [7:0] h, input logic tk);
        rs_valid = 1'b1; rs_pc = pc; rs_hist = h; rs_taken = tk;
        @(negedge clk);
        rs_valid = 1'b0;
        exp_ghr = {exp_ghr[6:0], tk};
    endtask

    task automatic predict_idx(input logic [10:0] idx, input logic exp, input string req);
        fc_pc = pc_for(idx, exp_ghr);
        #1;
        check(req, {31'd0, fc_taken}, {31'd0, exp});
    endtask

    task automatic t_reset();
        check("R1 history", {24'd0, fc_hist}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            predict_idx(11'(i * 517 + 3), 1'b0, "R1 counter");
        end
    endtask

    task automatic t_saturate_up();
        logic [10:0] e = 11'h155;
        for (int i = 0; i < 4; i++) resolve(pc_for(e, 8'h3C), 8'h3C, 1'b1);
        predict_idx(e, 1'b1, "R4 ceiling taken");
        resolve(pc_for(e, 8'h3C), 8'h3C, 1'b0);
        predict_idx(e, 1'b1, "R4 3->2 still taken");
        resolve(pc_for(e, 8'h3C), 8'h3C, 1'b0);
        predict_idx(e, 1'b0, "R2 msb 1 not taken");
    endtask

    task automatic t_saturate_down();
        logic [10:0] f = 11'h2A0;
        for (int i = 0; i < 3; i++) resolve(pc_for(f, 8'h81), 8'h81, 1'b0);
        resolve(pc_for(f, 8'h81), 8'h81, 1'b1);
        predict_idx(f, 1'b0, "R5 floor then +1");
        resolve(pc_for(f, 8'h81), 8'h81, 1'b1);
        predict_idx(f, 1'b1, "R5 floor +2 taken");
    endtask

    task automatic t_history();
        logic [7:0] held;
        resolve(32'h0000_4000, 8'h00, 1'b1);
        check("R7 shift taken", {24'd0, fc_hist}, {24'd0, exp_ghr});
        resolve(32'h0000_4000, 8'h00, 1'b0);
        check("R7 shift not taken", {24'd0, fc_hist}, {24'd0, exp_ghr});
        held = fc_hist;
        // idle with live-looking resolve inputs
        rs_pc = pc_for(11'h155, 8'h3C); rs_hist = 8'h3C; rs_taken = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 hold", {24'd0, fc_hist}, {24'd0, held});
        predict_idx(11'h155, 1'b0, "R9 no write when invalid");
    endtask

    task automatic t_snapshot();
        logic [10:0] g = 11'h0F0;
        logic [10:0] wrong;
        wrong = (g ^ 11'h0FF) ^ {3'd0, exp_ghr};
        resolve(pc_for(g, 8'hFF), 8'hFF, 1'b1);
        predict_idx(g, 1'b1, "R6 snapshot entry trained");
        predict_idx(wrong, 1'b0, "R6 current-history entry untouched");
        fc_pc = pc_for(g, exp_ghr) | 32'hABC0_0003;
        #1;
        check("R3 offset and high bits ignored", {31'd0, fc_taken}, 32'd1);
        fc_pc = pc_for(g, exp_ghr) ^ 32'h0000_1000;
        #1;
        check("R3 top index bit used", {31'd0, fc_taken}, 32'd0);
    endtask

    task automatic t_collision();
        logic [10:0] h = 11'h3FF;
        resolve(pc_for(h, exp_ghr), exp_ghr, 1'b1);
        rs_valid = 1'b1; rs_pc = pc_for(h, exp_ghr); rs_hist = exp_ghr; rs_taken = 1'b0;
        fc_pc = pc_for(h, exp_ghr);
        #1;
        check("R8 collision reads old", {31'd0, fc_taken}, 32'd1);
        @(negedge clk);
        rs_valid = 1'b0;
        exp_ghr = {exp_ghr[6:0], 1'b0};
        predict_idx(h, 1'b0, "R8 update applied after");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_saturate_up();
        t_saturate_down();
        t_history();
        t_snapshot();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule